// File: doc/BRIEF.md
# Engine CSR Arbiter with Collision Status

This block guards the local control and status register window of one processing engine. Two masters share that window: an external host port and the engine's own internal port. Both may present a request on the same clock. The arbiter gives no wait states and applies no backpressure. When both ports request on the same clock, the engine's access always completes. The host's read or write is discarded, and a status flag records the loss. Host software polls that flag after each access and retries until the flag reads clear.

The window is byte-addressed and one window's size wide; each engine's copy of the block sits at its own window-sized stride in the host address map. A small bank of generic 32-bit registers occupies the bottom of the window so that both ports have something to read and write. The read-only status word sits at a fixed offset that host software relies on. Engine accesses complete in the cycle they are presented. Host reads return data through a register, one clock after the request.

Top module: `engine_csr_arbiter`

## Requirements
- R1: After reset every generic register, the status flag, `host_rdata` and `host_rvalid` are zero.
- R2: A host access with no engine request on the same clock is performed. A host read raises `host_rvalid` for exactly the one cycle after its request clock, with the addressed data on `host_rdata`. Generic register i is at byte offset 4*i.
- R3: When the host and the engine request on the same clock and the host does not address the status word, the engine access is performed and the host write is not: the register it targeted keeps its old value.
- R4: A host read that loses arbitration still raises `host_rvalid` one cycle later, with `host_rdata` equal to zero.
- R5: A host access that loses arbitration sets the status flag. The status word at byte offset 0x180 reads with the flag in bit 0 and zeros in bits 31:1.
- R6: A host access that does not address the status word and meets no engine request clears the status flag.
- R7: A host read of the status word never collides: it returns the current flag even while the engine requests, and it leaves the flag unchanged.
- R8: Host writes to the status word have no effect on the flag.
- R9: `eng_rdata` shows the addressed word combinationally in the same cycle, including the status word, and engine writes take effect at the next clock edge.
- R10: A misaligned address (bits 1:0 not zero), or an aligned one above the generic bank other than the status word, maps to nothing: reads return zero and writes change no register. A host access to such an address still counts as a data access for R3 to R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access request, one cycle per access |
| host_we | input | 1 | Host access is a write when high |
| host_addr | input | ADDR_W (10) | Host byte address within the window |
| host_wdata | input | DATA_W (32) | Host write data |
| host_rdata | output | DATA_W (32) | Registered host read data |
| host_rvalid | output | 1 | Host read data valid, one cycle after a read request |
| eng_req | input | 1 | Engine access request |
| eng_we | input | 1 | Engine access is a write when high |
| eng_addr | input | ADDR_W (10) | Engine byte address within the window |
| eng_wdata | input | DATA_W (32) | Engine write data |
| eng_rdata | output | DATA_W (32) | Combinational engine read data |

## Verification
Host results come due one clock after the request edge: the write lands, the status flag updates, and `host_rvalid` and `host_rdata` change, all on that edge. Engine reads are due in the same cycle, with no edge. The bench drives every request on a falling edge and holds it through the next rising edge. It samples host outputs on the falling edge that follows, and samples engine read data a nanosecond after changing the engine address, before any rising edge. The effect of a lost access is observed only through later host or engine reads of the same register and the status word.

// File: rtl/csr_arb_pkg.sv
package csr_arb_pkg;

   // What an address inside the window selects
   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_GEN  = 2'd1,
      TGT_STAT = 2'd2
   } csr_tgt_e;

endpackage

// File: rtl/csr_arb_decode.sv
module csr_arb_decode
   import csr_arb_pkg::*;
#(
   parameter int ADDR_W     = 10,
   parameter int NUM_REGS   = 8,
   parameter int STATUS_OFS = 384,
   localparam int IDX_W     = $clog2(NUM_REGS),
   localparam int WORD_W    = ADDR_W - 2
) (
   input  logic [ADDR_W-1:0] addr,
   output csr_tgt_e          tgt,
   output logic [IDX_W-1:0]  idx
);

   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_OFS);
   localparam logic [WORD_W-1:0] NREG_W = WORD_W'(NUM_REGS);

   logic [WORD_W-1:0] word;

   assign word = addr[ADDR_W-1:2];
   assign idx  = word[IDX_W-1:0];

   always_comb begin
      if (addr == STAT_A)
         tgt = TGT_STAT;
      else if (addr[1:0] != 2'b00)
         tgt = TGT_NONE;
      else if (word < NREG_W)
         tgt = TGT_GEN;
      else
         tgt = TGT_NONE;
   end

endmodule

// File: rtl/csr_arb_core.sv
module csr_arb_core
   import csr_arb_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     host_req,
   input  logic     host_we,
   input  csr_tgt_e host_tgt,
   input  logic     eng_req,
   output logic     host_go,
   output logic     host_lost,
   output logic     host_rd,
   output logic     stat_flag,
   output logic     rvalid
);

   logic host_data;
   logic flag_q;
   logic rvalid_q;

   // Status reads are not data accesses: they never collide
   assign host_data = host_req && (host_tgt != TGT_STAT);
   assign host_lost = host_data && eng_req;
   assign host_go   = host_data && !eng_req;
   assign host_rd   = host_req && !host_we;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q   <= 1'b0;
         rvalid_q <= 1'b0;
      end else begin
         if (host_data)
            flag_q <= host_lost;
         rvalid_q <= host_rd;
      end
   end

   assign stat_flag = flag_q;
   assign rvalid    = rvalid_q;

endmodule

// File: rtl/csr_arb_regfile.sv
module csr_arb_regfile #(
   parameter int DATA_W   = 32,
   parameter int NUM_REGS = 8,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx_a,
   output logic [DATA_W-1:0] rd_data_a,
   input  logic [IDX_W-1:0]  rd_idx_b,
   output logic [DATA_W-1:0] rd_data_b
);

   logic [NUM_REGS*DATA_W-1:0] flat;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= '0;
         else if (wr_en && (wr_idx == IDX_W'(i)))
            q <= wr_data;
      end
      assign flat[i*DATA_W +: DATA_W] = q;
   end

   always_comb begin
      rd_data_a = '0;
      rd_data_b = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (rd_idx_a == IDX_W'(i))
            rd_data_a = flat[i*DATA_W +: DATA_W];
         if (rd_idx_b == IDX_W'(i))
            rd_data_b = flat[i*DATA_W +: DATA_W];
      end
   end

endmodule

// File: rtl/engine_csr_arbiter.sv
module engine_csr_arbiter
   import csr_arb_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int WINDOW_BYTES = 1024,
   parameter int NUM_REGS     = 8,
   parameter int STATUS_OFS   = 384,
   localparam int ADDR_W      = $clog2(WINDOW_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_req,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              host_rvalid,
   input  logic              eng_req,
   input  logic              eng_we,
   input  logic [ADDR_W-1:0] eng_addr,
   input  logic [DATA_W-1:0] eng_wdata,
   output logic [DATA_W-1:0] eng_rdata
);

   localparam int IDX_W = $clog2(NUM_REGS);

   // Elaboration-time parameter checks
   if ((1 << ADDR_W) != WINDOW_BYTES) begin : g_bad_window
      $error("WINDOW_BYTES must be a power of two");
   end
   if ((STATUS_OFS % 4) != 0 || STATUS_OFS >= WINDOW_BYTES) begin : g_bad_status
      $error("STATUS_OFS must be word aligned and inside the window");
   end
   if (NUM_REGS < 2 || NUM_REGS * 4 > STATUS_OFS) begin : g_bad_regs
      $error("NUM_REGS must be at least 2 and stay below STATUS_OFS");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be at least 2");
   end

   csr_tgt_e          host_tgt, eng_tgt;
   logic [IDX_W-1:0]  host_idx, eng_idx;
   logic              host_go, host_lost, host_rd;
   logic              stat_flag;
   logic              rvalid;
   logic [DATA_W-1:0] stat_word;
   logic [DATA_W-1:0] rf_host, rf_eng;
   logic              wr_en;
   logic [IDX_W-1:0]  wr_idx;
   logic [DATA_W-1:0] wr_data;
   logic [DATA_W-1:0] host_next;
   logic [DATA_W-1:0] host_rdata_q;

   csr_arb_decode #(
      .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .STATUS_OFS(STATUS_OFS)
   ) u_dec_host (
      .addr(host_addr), .tgt(host_tgt), .idx(host_idx)
   );

   csr_arb_decode #(
      .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .STATUS_OFS(STATUS_OFS)
   ) u_dec_eng (
      .addr(eng_addr), .tgt(eng_tgt), .idx(eng_idx)
   );

   csr_arb_core u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .host_req  (host_req),
      .host_we   (host_we),
      .host_tgt  (host_tgt),
      .eng_req   (eng_req),
      .host_go   (host_go),
      .host_lost (host_lost),
      .host_rd   (host_rd),
      .stat_flag (stat_flag),
      .rvalid    (rvalid)
   );

   // One writer per cycle: host_go already excludes any engine request
   always_comb begin
      wr_en   = 1'b0;
      wr_idx  = eng_idx;
      wr_data = eng_wdata;
      if (eng_req && eng_we && eng_tgt == TGT_GEN) begin
         wr_en = 1'b1;
      end else if (host_go && host_we && host_tgt == TGT_GEN) begin
         wr_en   = 1'b1;
         wr_idx  = host_idx;
         wr_data = host_wdata;
      end
   end

   csr_arb_regfile #(
      .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
   ) u_rf (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data),
      .rd_idx_a  (host_idx),
      .rd_data_a (rf_host),
      .rd_idx_b  (eng_idx),
      .rd_data_b (rf_eng)
   );

   assign stat_word = {{(DATA_W-1){1'b0}}, stat_flag};

   always_comb begin
      case (host_tgt)
         TGT_STAT: host_next = stat_word;
         TGT_GEN:  host_next = rf_host;
         default:  host_next = '0;
      endcase
      if (host_lost)
         host_next = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         host_rdata_q <= '0;
      else if (host_rd)
         host_rdata_q <= host_next;
   end

   always_comb begin
      case (eng_tgt)
         TGT_STAT: eng_rdata = stat_word;
         TGT_GEN:  eng_rdata = rf_eng;
         default:  eng_rdata = '0;
      endcase
   end

   assign host_rdata  = host_rdata_q;
   assign host_rvalid = rvalid;

endmodule

// File: rtl/csr_arb_chk.sv
module csr_arb_chk #(
   parameter int ADDR_W     = 10,
   parameter int DATA_W     = 32,
   parameter int STATUS_OFS = 384
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_req,
   input logic              host_we,
   input logic [ADDR_W-1:0] host_addr,
   input logic [DATA_W-1:0] host_rdata,
   input logic              host_rvalid,
   input logic              eng_req,
   input logic              stat_flag
);

   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_OFS);

   logic hstat;
   assign hstat = (host_addr == STAT_A);

   p_rvalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (host_req && !host_we) |=> host_rvalid);

   p_no_extra_rvalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_req && !host_we) |=> !host_rvalid);

   p_lost_read_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (host_req && !host_we && eng_req && !hstat) |=> (host_rdata == '0));

   p_collide_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (host_req && eng_req && !hstat) |=> stat_flag);

   p_success_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (host_req && !eng_req && !hstat) |=> !stat_flag);

   p_status_access_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (host_req && hstat) |=> $stable(stat_flag));

endmodule

bind engine_csr_arbiter csr_arb_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STATUS_OFS(STATUS_OFS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .host_req    (host_req),
   .host_we     (host_we),
   .host_addr   (host_addr),
   .host_rdata  (host_rdata),
   .host_rvalid (host_rvalid),
   .eng_req     (eng_req),
   .stat_flag   (stat_flag)
);

// File: tb/sim_engine_csr_arbiter.sv
`timescale 1ns/1ps
module sim_engine_csr_arbiter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_req = 1'b0, host_we = 1'b0;
   logic [9:0]  host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        host_rvalid;
   logic        eng_req = 1'b0, eng_we = 1'b0;
   logic [9:0]  eng_addr = '0;
   logic [31:0] eng_wdata = '0;
   logic [31:0] eng_rdata;

   int checks = 0;
   int errors = 0;
   logic        last_rvalid;
   logic [31:0] last_rdata;
   logic        done = 1'b0;

   localparam logic [9:0] STAT = 10'h180;

   always #4 clk = ~clk;

   engine_csr_arbiter u0 (
      .clk(clk), .rst_n(rst_n),
      .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
      .eng_req(eng_req), .eng_we(eng_we), .eng_addr(eng_addr),
      .eng_wdata(eng_wdata), .eng_rdata(eng_rdata)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Called on a falling edge; holds the request through one rising edge and
   // samples host outputs on the following falling edge.
   task automatic drive(input logic hr, input logic hw, input logic [9:0] ha,
                        input logic [31:0] hd, input logic er, input logic ew,
                        input logic [9:0] ea, input logic [31:0] ed);
      host_req = hr; host_we = hw; host_addr = ha; host_wdata = hd;
      eng_req = er; eng_we = ew; eng_addr = ea; eng_wdata = ed;
      @(posedge clk);
      @(negedge clk);
      last_rvalid = host_rvalid;
      last_rdata  = host_rdata;
      host_req = 1'b0; host_we = 1'b0; eng_req = 1'b0; eng_we = 1'b0;
   endtask

   task automatic hwrite(input logic [9:0] a, input logic [31:0] d);
      drive(1, 1, a, d, 0, 0, 0, 0);
   endtask

   task automatic hread(input logic [9:0] a, output logic [31:0] d);
      drive(1, 0, a, 0, 0, 0, 0, 0);
      d = last_rdata;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      chk("R1 rvalid after reset", 32'(host_rvalid), 0);
      chk("R1 rdata after reset", host_rdata, 0);
      hread(STAT, d);
      chk("R1 status after reset", d, 0);
      hread(10'h01C, d);
      chk("R1 reg7 after reset", d, 0);
   endtask

   task automatic t_host_access;
      logic [31:0] d;
      hwrite(10'h008, 32'hA5A5_1234);
      chk("R2 no rvalid after write", 32'(last_rvalid), 0);
      hread(10'h008, d);
      chk("R2 rvalid after read", 32'(last_rvalid), 1);
      chk("R2 read back reg2", d, 32'hA5A5_1234);
      drive(0, 0, 0, 0, 0, 0, 0, 0);
      chk("R2 rvalid lasts one cycle", 32'(last_rvalid), 0);
   endtask

   task automatic t_collide_write;
      logic [31:0] d;
      hwrite(10'h00C, 32'h0000_1111);
      drive(1, 1, 10'h00C, 32'hDEAD_BEEF, 1, 1, 10'h014, 32'h0000_5555);
      eng_addr = 10'h014; #1;
      chk("R3 engine write performed", eng_rdata, 32'h0000_5555);
      hread(STAT, d);
      chk("R5 status after lost write", d, 32'h1);
      hread(10'h00C, d);
      chk("R3 lost host write ignored", d, 32'h0000_1111);
      hread(STAT, d);
      chk("R6 status cleared by success", d, 32'h0);
   endtask

   task automatic t_collide_read;
      logic [31:0] d;
      hwrite(10'h010, 32'h0000_CAFE);
      drive(1, 0, 10'h010, 0, 1, 0, 10'h000, 0);
      chk("R4 rvalid on lost read", 32'(last_rvalid), 1);
      chk("R4 lost read data zero", last_rdata, 0);
      hread(STAT, d);
      chk("R5 status after lost read", d, 32'h1);
   endtask

   task automatic t_status_read;
      logic [31:0] d;
      drive(1, 0, STAT, 0, 1, 0, 10'h000, 0);
      chk("R7 status read during engine req", last_rdata, 32'h1);
      hread(STAT, d);
      chk("R7 status unchanged by status read", d, 32'h1);
      hread(10'h000, d);
      drive(1, 0, STAT, 0, 1, 1, 10'h000, 32'h0000_0042);
      chk("R7 clear status read during engine write", last_rdata, 32'h0);
      hread(STAT, d);
      chk("R7 status stays clear", d, 32'h0);
   endtask

   task automatic t_status_write;
      logic [31:0] d;
      drive(1, 1, 10'h018, 32'h9, 1, 0, 10'h000, 0);
      hwrite(STAT, 32'h0);
      hread(STAT, d);
      chk("R8 write 0 leaves flag set", d, 32'h1);
      hread(10'h000, d);
      hwrite(STAT, 32'hFFFF_FFFF);
      hread(STAT, d);
      chk("R8 write ones leaves flag clear", d, 32'h0);
      hread(10'h018, d);
      chk("R3 lost write to reg6 ignored", d, 32'h0);
   endtask

   task automatic t_engine_path;
      drive(0, 0, 0, 0, 1, 1, 10'h004, 32'h0000_0077);
      eng_addr = 10'h004; #1;
      chk("R9 engine reads reg1", eng_rdata, 32'h0000_0077);
      eng_addr = 10'h008; #1;
      chk("R9 engine reads reg2 same cycle", eng_rdata, 32'hA5A5_1234);
      eng_addr = STAT; #1;
      chk("R9 engine reads status", eng_rdata, 32'h0);
      @(negedge clk);
   endtask

   task automatic t_unmapped;
      logic [31:0] d;
      hwrite(10'h040, 32'h1234_5678);
      hread(10'h040, d);
      chk("R10 unmapped reads zero", d, 0);
      hwrite(10'h009, 32'hFFFF_0000);
      hread(10'h008, d);
      chk("R10 misaligned write ignored", d, 32'hA5A5_1234);
      hread(10'h009, d);
      chk("R10 misaligned read zero", d, 0);
      drive(1, 1, 10'h3FC, 32'h1, 1, 0, 10'h000, 0);
      hread(STAT, d);
      chk("R10 unmapped lost access sets flag", d, 32'h1);
      drive(0, 0, 0, 0, 1, 1, 10'h044, 32'hABCD);
      eng_addr = 10'h044; #1;
      chk("R10 engine unmapped reads zero", eng_rdata, 0);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_host_access;
      t_collide_write;
      t_collide_read;
      t_status_read;
      t_status_write;
      t_engine_path;
      t_unmapped;
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule